// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 device from power-on to a usable state with no processor involved. After the block leaves reset it holds the memory in reset for a power-on delay. It then releases the memory reset and raises the clock-enable and termination pins. Next it takes clock-enable low and back high, with a wait after each step. It then issues the four mode-register writes with preset values and a long ZQ calibration. Last, it raises a sticky `done` flag so that the memory controller can take the command bus.

The command outputs are DFI-like and active low (`cs_n`, `ras_n`, `cas_n`, `we_n`), with address and bank beside them. Every delay is a parameter counted in clock cycles. Real-time values at 125 MHz are the defaults, and a simulation can pass much smaller ones. Every wait parameter must be at least 1.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is low, and for the first `T_POR` cycles after it is released, `cke`, `mem_rst_n`, `odt` and `done` are 0. In these cycles `cs_n`, `ras_n`, `cas_n` and `we_n` are 1, and address and bank are 0.
- R2: In the next single cycle, `cke`, `mem_rst_n` and `odt` are all 1 and a NOP is driven.
- R3: For the next `T_CKE_LOW` cycles, `cke` is 0 while `mem_rst_n` and `odt` stay 1, with address and bank 0.
- R4: `cke` then returns to 1, and it stays 1 for `T_CKE_HIGH` cycles before the first mode-register write.
- R5: Four mode-register writes follow, in this order: address 0x200 bank 2, then 0x000 bank 3, then 0x006 bank 1, then 0x320 bank 0. Each is encoded as `cs_n`, `ras_n`, `cas_n` and `we_n` all 0.
- R6: Consecutive mode-register writes are `1+T_MRD` cycles apart, with NOPs in between.
- R7: After the last mode-register write come `T_ZQ_PRE` NOP cycles, then a ZQ calibration command. This command has `cs_n`=0, `we_n`=0, `ras_n`=1 and `cas_n`=1, address 0x400 and bank 0.
- R8: Each command lasts exactly one cycle. After reset, every cycle with no command is a NOP (`cs_n`=0, the other three strobes 1) with address and bank 0. The `T_ZQ_POST` cycles that follow the ZQ calibration are NOPs.
- R9: After those cycles `done` goes to 1. It then stays 1, with `cke`, `mem_rst_n` and `odt` at 1 and a NOP driven, until reset.
- R10: Taking `rst_n` low at any point, including a command cycle or a cycle with `done` high, returns all outputs to the R1 state at once. The full sequence then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| mem_rst_n | output | 1 | Memory reset, active low |
| odt | output | 1 | On-die termination enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | BW | Bank address |
| addr | output | AW | Row/mode address |
| done | output | 1 | Initialization complete, sticky |

## Verification
Reset can land in the same cycle as a command or as the `done` handover. The bench provokes this by dropping `rst_n` in four places: the cycle of the second mode-register write, the cycle of the ZQ calibration command, the single cycle in which all pins are raised, and a cycle with `done` already high. In each case it expects the outputs to show the power-on state straight away, with no strobe left low and `done` cleared. It then expects the whole sequence to replay. Every cycle is compared with a timeline that the bench computes by arithmetic from the delay parameters.

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq #(
  parameter int T_POR      = 87500,
  parameter int T_CKE_LOW  = 62500,
  parameter int T_CKE_HIGH = 62500,
  parameter int T_MRD      = 4,
  parameter int T_ZQ_PRE   = 250,
  parameter int T_ZQ_POST  = 250,
  parameter int AW         = 14,
  parameter int BW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          cke,
  output logic          mem_rst_n,
  output logic          odt,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [BW-1:0] bank,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam int M1   = (T_POR > T_CKE_LOW) ? T_POR : T_CKE_LOW;
  localparam int M2   = (M1 > T_CKE_HIGH) ? M1 : T_CKE_HIGH;
  localparam int M3   = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int M4   = (M3 > T_ZQ_PRE) ? M3 : T_ZQ_PRE;
  localparam int MAXD = (M4 > T_ZQ_POST) ? M4 : T_ZQ_POST;
  localparam int CW   = $clog2(MAXD + 1);

  typedef enum logic [3:0] {
    ST_POR, ST_PWR, ST_CKEL, ST_CKEH, ST_MRS, ST_GAP, ST_ZQ, ST_ZQW, ST_DONE
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [1:0]   mr;
  wire          zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_POR;
      cnt <= CW'(T_POR - 1);
      mr  <= '0;
    end else begin
      case (st)
        ST_POR:  if (zero) st <= ST_PWR; else cnt <= cnt - 1'b1;
        ST_PWR:  begin st <= ST_CKEL; cnt <= CW'(T_CKE_LOW - 1); end
        ST_CKEL: if (zero) begin st <= ST_CKEH; cnt <= CW'(T_CKE_HIGH - 1); end
                 else cnt <= cnt - 1'b1;
        ST_CKEH: if (zero) st <= ST_MRS; else cnt <= cnt - 1'b1;
        ST_MRS:  begin
                   st  <= ST_GAP;
                   cnt <= (mr == 2'd3) ? CW'(T_ZQ_PRE - 1) : CW'(T_MRD - 1);
                 end
        ST_GAP:  if (zero) begin
                   if (mr == 2'd3) st <= ST_ZQ;
                   else begin mr <= mr + 1'b1; st <= ST_MRS; end
                 end else cnt <= cnt - 1'b1;
        ST_ZQ:   begin st <= ST_ZQW; cnt <= CW'(T_ZQ_POST - 1); end
        ST_ZQW:  if (zero) st <= ST_DONE; else cnt <= cnt - 1'b1;
        default: st <= ST_DONE;
      endcase
    end
  end

  wire is_mrs = (st == ST_MRS);
  wire is_zq  = (st == ST_ZQ);

  assign mem_rst_n = (st != ST_POR);
  assign odt       = mem_rst_n;
  assign cke       = mem_rst_n && (st != ST_CKEL);
  assign cs_n      = !mem_rst_n;
  assign ras_n     = !is_mrs;
  assign cas_n     = !is_mrs;
  assign we_n      = !(is_mrs || is_zq);
  assign done      = (st == ST_DONE);

  always_comb begin
    addr = '0;
    bank = '0;
    if (is_zq) addr = AW'(12'h400);
    else if (is_mrs) begin
      case (mr)
        2'd0: begin addr = AW'(12'h200); bank = BW'(2); end
        2'd1: begin addr = AW'(12'h000); bank = BW'(3); end
        2'd2: begin addr = AW'(12'h006); bank = BW'(1); end
        default: begin addr = AW'(12'h320); bank = BW'(0); end
      endcase
    end
  end

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r8_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !ras_n) |=> (we_n && ras_n && cas_n));
  a_r8_nop_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && ras_n && cas_n) |-> (addr == '0 && bank == '0));
  a_r5_cmd_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |-> (cke && mem_rst_n && odt && !cs_n));
  a_r9_done_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cke && mem_rst_n && odt && we_n));
endmodule

// File: tb/ddr3_init_seq_tb.sv
module ddr3_init_seq_tb;
  localparam int P = 8, CL = 5, CH = 6, MRD = 3, PRE = 7, POST = 9;
  localparam int B  = P + 1 + CL + CH;
  localparam int L3 = B + 3 * (1 + MRD);
  localparam int Z  = L3 + 1 + PRE;
  localparam int D  = Z + 1 + POST;

  logic clk = 0, rst_n = 0;
  logic cke, mem_rst_n, odt, cs_n, ras_n, cas_n, we_n, done;
  logic [2:0] bank;
  logic [13:0] addr;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  ddr3_init_seq #(.T_POR(P), .T_CKE_LOW(CL), .T_CKE_HIGH(CH), .T_MRD(MRD),
    .T_ZQ_PRE(PRE), .T_ZQ_POST(POST), .AW(14), .BW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .mem_rst_n(mem_rst_n), .odt(odt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bank(bank),
    .addr(addr), .done(done));

  // {cke, mem_rst_n, odt, cs_n, ras_n, cas_n, we_n, bank, addr, done}
  function automatic logic [24:0] pk(bit c, bit r, bit o, logic [3:0] cmd,
                                     logic [2:0] b, logic [13:0] a, bit d);
    return {c, r, o, cmd, b, a, d};
  endfunction

  function automatic logic [24:0] expv(int n, output string req);
    logic [3:0] nop = 4'b0111;
    int k;
    if (n < P) begin req = "R1"; return pk(0,0,0,4'b1111,0,0,0); end
    if (n == P) begin req = "R2"; return pk(1,1,1,nop,0,0,0); end
    if (n <= P + CL) begin req = "R3"; return pk(0,1,1,nop,0,0,0); end
    if (n < B) begin req = "R4"; return pk(1,1,1,nop,0,0,0); end
    if (n <= L3) begin
      if ((n - B) % (1 + MRD) == 0) begin
        req = "R5";
        k = (n - B) / (1 + MRD);
        case (k)
          0: return pk(1,1,1,4'b0000,3'd2,14'h200,0);
          1: return pk(1,1,1,4'b0000,3'd3,14'h000,0);
          2: return pk(1,1,1,4'b0000,3'd1,14'h006,0);
          default: return pk(1,1,1,4'b0000,3'd0,14'h320,0);
        endcase
      end
      req = "R6"; return pk(1,1,1,nop,0,0,0);
    end
    if (n < Z) begin req = "R7"; return pk(1,1,1,nop,0,0,0); end
    if (n == Z) begin req = "R7"; return pk(1,1,1,4'b0110,0,14'h400,0); end
    if (n < D) begin req = "R8"; return pk(1,1,1,nop,0,0,0); end
    req = "R9"; return pk(1,1,1,nop,0,0,1);
  endfunction

  function automatic logic [24:0] act();
    return {cke, mem_rst_n, odt, cs_n, ras_n, cas_n, we_n, bank, addr, done};
  endfunction

  task automatic chk(logic [24:0] e, string req, int n);
    checks++;
    if (act() !== e) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, n, act(), e);
    end
  endtask

  task automatic run(int last, bit rst_at_end);
    string req;
    logic [24:0] e;
    for (int n = 0; n <= last; n++) begin
      if (n > 0) @(negedge clk);
      e = expv(n, req);
      chk(e, req, n);
    end
    if (rst_at_end) begin
      rst_n = 0;
      #1;
      e = expv(0, req);
      chk(e, "R10", last);
      @(negedge clk);
      chk(e, "R10", last);
      rst_n = 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    string req;
    repeat (3) @(negedge clk);
    chk(expv(0, req), "R1", 0);
    rst_n = 1;
    run(D + 20, 1);      // R9 sticky done, then R10 reset while done
    run(B + 1 + MRD, 1); // R10 reset during second mode-register write
    run(Z, 1);           // R10 reset during ZQ calibration command
    run(P, 1);           // R10 reset during the pins-high cycle
    run(D + 5, 0);       // full replay
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule